// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps the wall-clock state of a real-time clock: seconds, minutes, hours, day of month, month, two-digit year and century, one byte each. Every cycle in which the update pulse is high, the seconds field advances and carries ripple upward through the calendar. Day rollover follows the length of the current month, including leap Februaries.

Two mode inputs choose how the bytes are interpreted. One selects packed BCD or plain binary. The other selects a 24-hour clock or a 12-hour clock with a PM flag. The host loads any field through a one-hot write strobe and a shared data byte. The current values are always visible on parallel outputs.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted, seconds, minutes, hours, year and century read 0, and day and month read 1 (parameter defaults).
- R2: A high `wr_en[k]` loads `wr_data` unchanged into field k on the next clock edge. Any byte is accepted, for example year 0x80 with century 0x19. Strobe bits are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 century. A write wins over an increment of the same field in the same cycle, and the carry computed from the old value still reaches the next field.
- R3: In a cycle with neither `tick` nor any write strobe, every field holds its value.
- R4: A cycle with `tick` high advances seconds by one on the following edge. Seconds at 59 go to 0 and advance minutes. Minutes at 59 go to 0 and advance hours.
- R5: `data_bin` = 0 treats every field as two BCD digits, so 0x09 advances to 0x10. `data_bin` = 1 treats every field as a binary count.
- R6: With `hr24` = 1, hours count 0..23, and 23 rolls to 0 with a carry into the day.
- R7: With `hr24` = 0, bit 7 of hours is PM and the low bits hold 1..12 (noon 0x92 BCD / 0x8C binary, midnight 0x12 / 0x0C). Rollovers are: 12 goes to 1 with PM kept; 11 AM goes to 12 PM; 11 PM goes to 12 AM, and only that last step carries into the day.
- R8: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February, and each wrap advances the month.
- R9: February wraps after day 29 in a leap year and after day 28 otherwise. A leap year has year divisible by 4, except that year 00 is a leap year only when the century is divisible by 4.
- R10: Month 12 rolls to 1 and advances the year. Year 99 rolls to 0 and advances the century. Century 99 rolls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Update pulse; one second step per high cycle |
| data_bin | input | 1 | 0 = BCD fields, 1 = binary fields |
| hr24 | input | 1 | 1 = 24-hour clock, 0 = 12-hour clock with PM in bit 7 |
| wr_en | input | 7 | One-hot field write strobe |
| wr_data | input | 8 | Byte loaded into the strobed field |
| sec_q | output | 8 | Seconds |
| min_q | output | 8 | Minutes |
| hour_q | output | 8 | Hours |
| day_q | output | 8 | Day of month |
| mon_q | output | 8 | Month |
| year_q | output | 8 | Year within century |
| cent_q | output | 8 | Century |

## Verification
Some rules are checked on every cycle. These are holding when idle, write priority, the seconds step and wrap, hours staying put while no minute carry is due, midnight in 24-hour mode, and the PM flag toggling at the 11 o'clock boundary in 12-hour mode. Month lengths, leap-year rules, the year and century rollover, and the interplay between a write and a carry in the same cycle depend on calendar state several fields deep. These are shown only by the bench's scenarios, which compare every field against a behavioural model on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int FIELD_W    = 8;
   localparam int NUM_FIELDS = 7;

   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;
   localparam int F_CENT = 6;

   typedef logic [FIELD_W-1:0] fld_t;

   // encoded field -> binary count
   function automatic fld_t dec_val(fld_t v, logic bin_mode);
      if (bin_mode) return v;
      return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
   endfunction

   // binary count (< 100 in BCD) -> encoded field
   function automatic fld_t enc_val(fld_t n, logic bin_mode);
      if (bin_mode) return n;
      return ((n / 8'd10) << 4) | (n % 8'd10);
   endfunction

   function automatic fld_t field_lo(int idx);
      return (idx == F_DAY || idx == F_MON) ? 8'd1 : 8'd0;
   endfunction

   function automatic fld_t field_hi(int idx);
      case (idx)
         F_SEC, F_MIN: return 8'd59;
         F_HOUR:       return 8'd23;
         F_MON:        return 8'd12;
         default:      return 8'd99;
      endcase
   endfunction

endpackage

// File: rtl/tod_step.sv
module tod_step
   import tod_pkg::*;
(
   input  fld_t cur,
   input  logic bin_mode,
   input  fld_t lo,
   input  fld_t hi,
   output fld_t nxt,
   output logic wrap
);
   fld_t n;

   always_comb begin
      n    = dec_val(cur, bin_mode);
      wrap = (n >= hi);
      nxt  = enc_val(wrap ? lo : n + 8'd1, bin_mode);
   end
endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step
   import tod_pkg::*;
(
   input  fld_t cur,
   input  logic bin_mode,
   input  logic h24,
   output fld_t nxt,
   output logic wrap
);
   fld_t n;
   fld_t l;
   logic pm;

   always_comb begin
      wrap = 1'b0;
      pm   = cur[7];
      l    = 8'd1;
      if (h24) begin
         n    = dec_val(cur, bin_mode);
         wrap = (n >= field_hi(F_HOUR));
         nxt  = enc_val(wrap ? 8'd0 : n + 8'd1, bin_mode);
      end else begin
         n = dec_val({1'b0, cur[6:0]}, bin_mode);
         if (n >= 8'd12) begin
            l = 8'd1;
         end else if (n == 8'd11) begin
            l    = 8'd12;
            wrap = pm;
            pm   = ~pm;
         end else begin
            l = n + 8'd1;
         end
         nxt = enc_val(l, bin_mode) | {pm, 7'd0};
      end
   end
endmodule

// File: rtl/tod_month_len.sv
module tod_month_len
   import tod_pkg::*;
(
   input  fld_t mon,
   input  fld_t year,
   input  fld_t cent,
   input  logic bin_mode,
   output fld_t days
);
   fld_t m, y, c;
   logic leap;

   always_comb begin
      m    = dec_val(mon, bin_mode);
      y    = dec_val(year, bin_mode);
      c    = dec_val(cent, bin_mode);
      leap = ((y % 8'd4) == 8'd0) && ((y != 8'd0) || ((c % 8'd4) == 8'd0));
      case (m)
         8'd2:                    days = leap ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11: days = 8'd30;
         default:                 days = 8'd31;
      endcase
   end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter logic [7:0] RST_DAY  = 8'h01,
   parameter logic [7:0] RST_MON  = 8'h01,
   parameter logic [7:0] RST_YEAR = 8'h00,
   parameter logic [7:0] RST_CENT = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  data_bin,
   input  logic                  hr24,
   input  logic [NUM_FIELDS-1:0] wr_en,
   input  logic [FIELD_W-1:0]    wr_data,
   output logic [FIELD_W-1:0]    sec_q,
   output logic [FIELD_W-1:0]    min_q,
   output logic [FIELD_W-1:0]    hour_q,
   output logic [FIELD_W-1:0]    day_q,
   output logic [FIELD_W-1:0]    mon_q,
   output logic [FIELD_W-1:0]    year_q,
   output logic [FIELD_W-1:0]    cent_q
);
   localparam fld_t RST_VAL [NUM_FIELDS] =
      '{8'h00, 8'h00, 8'h00, RST_DAY, RST_MON, RST_YEAR, RST_CENT};

   if (RST_DAY == 8'h00) begin : g_bad_day
      $error("tod_counter: RST_DAY must be non-zero");
   end
   if (RST_MON == 8'h00) begin : g_bad_mon
      $error("tod_counter: RST_MON must be non-zero");
   end

   fld_t                  fld [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] cin;
   fld_t                  mlen;

   assign cin[0] = tick;

   tod_month_len u_mlen (
      .mon      (fld[F_MON]),
      .year     (fld[F_YEAR]),
      .cent     (fld[F_CENT]),
      .bin_mode (data_bin),
      .days     (mlen)
   );

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      fld_t nxt;
      fld_t q_r;

      if (i == F_HOUR) begin : g_hour
         logic wr_o;
         tod_hour_step u_hs (
            .cur      (fld[i]),
            .bin_mode (data_bin),
            .h24      (hr24),
            .nxt      (nxt),
            .wrap     (wr_o)
         );
         assign cin[i+1] = cin[i] & wr_o;
      end else if (i == NUM_FIELDS - 1) begin : g_last
         fld_t n_c;
         assign n_c = dec_val(fld[i], data_bin);
         assign nxt = enc_val((n_c >= field_hi(i)) ? field_lo(i) : n_c + 8'd1, data_bin);
      end else begin : g_std
         logic wr_o;
         tod_step u_st (
            .cur      (fld[i]),
            .bin_mode (data_bin),
            .lo       (field_lo(i)),
            .hi       ((i == F_DAY) ? mlen : field_hi(i)),
            .nxt      (nxt),
            .wrap     (wr_o)
         );
         assign cin[i+1] = cin[i] & wr_o;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_r <= RST_VAL[i];
         else if (wr_en[i]) q_r <= wr_data;
         else if (cin[i])   q_r <= nxt;
      end

      assign fld[i] = q_r;
   end

   assign sec_q  = fld[F_SEC];
   assign min_q  = fld[F_MIN];
   assign hour_q = fld[F_HOUR];
   assign day_q  = fld[F_DAY];
   assign mon_q  = fld[F_MON];
   assign year_q = fld[F_YEAR];
   assign cent_q = fld[F_CENT];
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       data_bin,
   input logic       hr24,
   input logic [6:0] wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] sec_q,
   input logic [7:0] min_q,
   input logic [7:0] hour_q,
   input logic [7:0] day_q,
   input logic [7:0] mon_q,
   input logic [7:0] year_q,
   input logic [7:0] cent_q
);
   logic sec59, min59, hour23, low11;
   assign sec59  = data_bin ? (sec_q == 8'd59) : (sec_q == 8'h59);
   assign min59  = data_bin ? (min_q == 8'd59) : (min_q == 8'h59);
   assign hour23 = data_bin ? (hour_q == 8'd23) : (hour_q == 8'h23);
   assign low11  = data_bin ? (hour_q[6:0] == 7'd11) : (hour_q[6:0] == 7'h11);

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && wr_en == 7'd0) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                                    $stable(day_q) && $stable(mon_q) && $stable(year_q) &&
                                    $stable(cent_q)));

   p_write_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[0] |=> (sec_q == $past(wr_data)));

   p_write_hour_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[2] |=> (hour_q == $past(wr_data)));

   p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en[0] && data_bin && !sec59) |=> (sec_q == $past(sec_q) + 8'd1));

   p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en[0] && sec59) |=> (sec_q == 8'd0));

   p_hour_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wr_en == 7'd0 && !(sec59 && min59)) |=> $stable(hour_q));

   p_midnight_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wr_en == 7'd0 && hr24 && hour23 && min59 && sec59) |=> (hour_q == 8'd0));

   p_pm_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wr_en == 7'd0 && !hr24 && low11 && min59 && sec59) |=> (hour_q[7] != $past(hour_q[7])));
endmodule

bind tod_counter tod_counter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .data_bin(data_bin), .hr24(hr24),
   .wr_en(wr_en), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
   .day_q(day_q), .mon_q(mon_q), .year_q(year_q), .cent_q(cent_q)
);

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       data_bin = 1'b0;
   logic       hr24 = 1'b1;
   logic [6:0] wr_en = 7'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] sec_q, min_q, hour_q, day_q, mon_q, year_q, cent_q;

   int    total = 0;
   int    bad = 0;
   string cur_tag = "R1";
   string names [7] = '{"sec", "min", "hour", "day", "month", "year", "century"};
   int    m [7];
   logic [7:0] dq [7];

   always #5 clk = ~clk;

   tod_counter dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .data_bin(data_bin), .hr24(hr24),
      .wr_en(wr_en), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
      .day_q(day_q), .mon_q(mon_q), .year_q(year_q), .cent_q(cent_q)
   );

   assign dq[0] = sec_q;  assign dq[1] = min_q;  assign dq[2] = hour_q;
   assign dq[3] = day_q;  assign dq[4] = mon_q;  assign dq[5] = year_q;
   assign dq[6] = cent_q;

   // ---------------- behavioural reference model ----------------
   function automatic int dec(int v);
      return data_bin ? v : ((v >> 4) * 10 + (v & 15));
   endfunction
   function automatic int enc(int n);
      return data_bin ? n : (((n / 10) << 4) | (n % 10));
   endfunction
   function automatic int month_days();
      int mo = dec(m[4]);
      int yr = dec(m[5]);
      int ce = dec(m[6]);
      bit leap = (yr % 4 == 0) && (yr != 0 || ce % 4 == 0);
      if (mo == 2) return leap ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   // advance one counter field; returns 1 on wrap
   function automatic bit bump(int idx, int lo, int hi);
      int v = dec(m[idx]);
      bit w = (v >= hi);
      m[idx] = enc(w ? lo : v + 1);
      return w;
   endfunction

   task automatic model_tick();
      bit c;
      c = bump(0, 0, 59);
      if (c) c = bump(1, 0, 59);
      if (c) begin
         if (hr24) c = bump(2, 0, 23);
         else begin
            int  l  = dec(m[2] & 8'h7f);
            bit  pm = m[2][7];
            c = 1'b0;
            if (l >= 12) l = 1;
            else if (l == 11) begin l = 12; c = pm; pm = !pm; end
            else l = l + 1;
            m[2] = enc(l) | (pm ? 8'h80 : 8'h00);
         end
      end
      if (c) c = bump(3, 1, month_days());
      if (c) c = bump(4, 1, 12);
      if (c) c = bump(5, 0, 99);
      if (c) c = bump(6, 0, 99);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m = '{0, 0, 0, 1, 1, 0, 0};
      end else begin
         if (tick) model_tick();
         for (int i = 0; i < 7; i++) if (wr_en[i]) m[i] = wr_data;
      end
   end

   // compare every field against the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 7; i++) begin
            total++;
            if (dq[i] !== m[i][7:0]) begin
               bad++;
               $display("FAIL %s model %s actual=%h expected=%h", cur_tag, names[i], dq[i], m[i][7:0]);
            end
         end
      end
   end

   // ---------------- stimulus helpers (called at a falling edge) ----------------
   task automatic expect_f(string tag, int idx, int exp);
      total++;
      if (dq[idx] !== exp[7:0]) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, names[idx], dq[idx], exp[7:0]);
      end
   endtask

   task automatic wr(int idx, int val);
      wr_en = 7'(1 << idx);
      wr_data = val[7:0];
      @(negedge clk);
      wr_en = 7'd0;
   endtask

   task automatic ticks(int n);
      repeat (n) begin tick = 1'b1; @(negedge clk); end
      tick = 1'b0;
   endtask

   task automatic set_hms(int h, int mi, int s);
      wr(2, h); wr(1, mi); wr(0, s);
   endtask

   task automatic set_date(int d, int mo, int y, int c);
      wr(6, c); wr(5, y); wr(4, mo); wr(3, d);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_tag = "R1";
      expect_f("R1", 0, 0); expect_f("R1", 2, 0); expect_f("R1", 3, 1);
      expect_f("R1", 4, 1); expect_f("R1", 6, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5: BCD 24h, minute carry 09:59 -> 10:00
      cur_tag = "R5"; data_bin = 1'b0; hr24 = 1'b1;
      set_hms(8'h09, 8'h59, 8'h00);
      ticks(1);  expect_f("R4", 0, 8'h01);
      ticks(8);  expect_f("R5", 0, 8'h09);
      ticks(1);  expect_f("R5", 0, 8'h10);
      ticks(50); expect_f("R5", 2, 8'h10); expect_f("R4", 1, 8'h00); expect_f("R4", 0, 8'h00);

      // R6: binary 24h midnight with day carry
      cur_tag = "R6"; data_bin = 1'b1;
      set_hms(23, 59, 59);
      ticks(1); expect_f("R6", 2, 0); expect_f("R6", 3, 2);

      // R7: BCD 12h
      cur_tag = "R7"; data_bin = 1'b0; hr24 = 1'b0;
      set_hms(8'h81, 8'h59, 8'h00);
      ticks(60); expect_f("R4", 2, 8'h82); expect_f("R4", 1, 8'h00);
      set_hms(8'h12, 8'h59, 8'h59); ticks(1); expect_f("R7", 2, 8'h01);
      set_hms(8'h92, 8'h59, 8'h59); ticks(1); expect_f("R7", 2, 8'h81);
      set_hms(8'h11, 8'h59, 8'h59); ticks(1); expect_f("R7", 2, 8'h92); expect_f("R7", 3, 8'h02);
      set_hms(8'h91, 8'h59, 8'h59); ticks(1); expect_f("R7", 2, 8'h12); expect_f("R7", 3, 8'h03);

      // R7: binary 12h
      data_bin = 1'b1;
      set_hms(8'h8c, 59, 59); ticks(1); expect_f("R7", 2, 8'h81);
      set_hms(8'h0c, 59, 59); ticks(1); expect_f("R7", 2, 8'h01);
      set_hms(8'h0b, 59, 59); ticks(1); expect_f("R7", 2, 8'h8c);
      set_hms(8'h8b, 59, 59); ticks(1); expect_f("R7", 2, 8'h0c);

      // R8: month lengths (BCD, 24h)
      cur_tag = "R8"; data_bin = 1'b0; hr24 = 1'b1;
      set_date(8'h30, 8'h04, 8'h11, 8'h20); set_hms(8'h23, 8'h59, 8'h59);
      ticks(1); expect_f("R8", 3, 8'h01); expect_f("R8", 4, 8'h05);
      set_date(8'h30, 8'h01, 8'h11, 8'h20); set_hms(8'h23, 8'h59, 8'h59);
      ticks(1); expect_f("R8", 3, 8'h31); expect_f("R8", 4, 8'h01);

      // R10: end of century
      cur_tag = "R10";
      set_date(8'h31, 8'h12, 8'h99, 8'h19); set_hms(8'h23, 8'h59, 8'h59);
      ticks(1); expect_f("R10", 3, 8'h01); expect_f("R10", 4, 8'h01);
      expect_f("R10", 5, 8'h00); expect_f("R10", 6, 8'h20);

      // R9: leap years (binary)
      cur_tag = "R9"; data_bin = 1'b1;
      set_date(28, 2, 23, 20); set_hms(23, 59, 59); ticks(1);
      expect_f("R9", 3, 1); expect_f("R9", 4, 3);
      set_date(28, 2, 24, 20); set_hms(23, 59, 59); ticks(1);
      expect_f("R9", 3, 29); expect_f("R9", 4, 2);
      set_date(28, 2, 0, 20); set_hms(23, 59, 59); ticks(1);
      expect_f("R9", 3, 29);
      set_date(28, 2, 0, 19); set_hms(23, 59, 59); ticks(1);
      expect_f("R9", 3, 1); expect_f("R9", 4, 3);

      // R2: storage and write priority
      cur_tag = "R2"; data_bin = 1'b0;
      wr(5, 8'h80); wr(6, 8'h19);
      expect_f("R2", 5, 8'h80); expect_f("R2", 6, 8'h19);
      set_hms(8'h10, 8'h20, 8'h59);
      tick = 1'b1; wr_en = 7'b0000001; wr_data = 8'h30;
      @(negedge clk);
      tick = 1'b0; wr_en = 7'd0;
      expect_f("R2", 0, 8'h30); expect_f("R2", 1, 8'h21);

      // R3: idle hold
      cur_tag = "R3";
      repeat (20) @(negedge clk);
      expect_f("R3", 0, 8'h30); expect_f("R3", 1, 8'h21); expect_f("R3", 5, 8'h80);

      summary();
      $finish;
   end
endmodule